// File: doc/BRIEF.md
# Pixel-to-Word Stream Packer

This block sits between a pixel source and a wide memory path. It receives one 16-bit pixel per handshake, together with the pixel's column and row inside the frame. It packs eight consecutive pixels into one 128-bit word and offers that word downstream on a ready/valid stream with a last flag.

The block detects the end of a frame from the coordinates. The bottom-right pixel (column `H_PIX-1`, row `V_PIX-1`) closes the frame, and the packed word that holds it leaves with the last flag set. With the default 1280x720 geometry the frame always ends on a full word. A smaller geometry whose pixel count is not a multiple of eight ends the frame on a partial word, and the remaining slots are filled with zeros.

A single output register holds the finished word. While that word is waiting and the consumer is not ready, the block withdraws its own input ready, so no pixel is lost.

Top module: `pixel_word_packer`

## Requirements
- R1: Within a word, the first accepted pixel of the group occupies bits [15:0]. Each later pixel occupies the next higher 16-bit slice in arrival order (slot j is bits [16j+15:16j]).
- R2: A word is presented (`out_valid` high) only after eight pixels have been accepted since the previous word, or earlier when R4 applies. The word appears on the cycle after the handshake of its final pixel.
- R3: An accepted pixel is marked frame end exactly when `in_hpos == H_PIX-1` and `in_vpos == V_PIX-1`. The word that contains this pixel is presented with `out_last` high, and every other word has `out_last` low.
- R4: When a frame-end pixel arrives with fewer than eight pixels gathered, the partial word is emitted immediately with `out_last` high. Its unused higher slots are zero, and the next pixel starts a new word at slot 0.
- R5: A word leaves only on a cycle where `out_valid` and `out_ready` are both high. While it is stalled, `out_valid`, `out_data` and `out_last` keep their values. Every accepted pixel appears exactly once, in order.
- R6: `in_ready` is low whenever a word is presented and `out_ready` is low. Otherwise `in_ready` is high.
- R7: A synchronous active-high reset clears `out_valid` and discards any partially gathered pixels. The first pixel accepted after reset lands in slot 0.
- R8: After a word is taken, `out_valid` drops on the next cycle unless a new word was completed on the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Pixel offered |
| in_ready | output | 1 | Block can accept a pixel |
| in_pixel | input | PIX_W (16) | Pixel value |
| in_hpos | input | HPOS_W (11) | Column index of the pixel |
| in_vpos | input | VPOS_W (10) | Row index of the pixel |
| out_valid | output | 1 | Packed word offered |
| out_ready | input | 1 | Consumer accepts the word |
| out_data | output | PIX_W*LANES (128) | Packed word |
| out_last | output | 1 | Word holds the last pixel of a frame |

## Verification
The bound checker watches a set of properties on every cycle:
- the held word stays unchanged while it is stalled;
- input ready is withdrawn under output backpressure;
- a frame-end pixel is followed by a word with the last flag set;
- a group that reaches eight pixels is followed by a word;
- a taken word with no successor drops its valid;
- valid is clear right after reset.

Slot order, the zero fill of a partial word and the loss-free, in-order delivery across many frames can only be shown by the bench's scenarios. The bench runs a small 4x3 frame, so every frame ends on a four-pixel partial word. It compares every word against values computed from the pixel index, under steady, gapped and backpressured traffic and after a reset that interrupts a group.

// File: rtl/pixpack_pkg.sv
package pixpack_pkg;

    localparam int DEF_PIX_W = 16;
    localparam int DEF_LANES = 8;
    localparam int DEF_H_PIX = 1280;
    localparam int DEF_V_PIX = 720;

    // Width needed to index n items, never less than one bit.
    function automatic int idx_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/pp_frame_end.sv
module pp_frame_end
    import pixpack_pkg::*;
#(
    parameter int H_PIX  = DEF_H_PIX,
    parameter int V_PIX  = DEF_V_PIX,
    parameter int HPOS_W = idx_width(DEF_H_PIX),
    parameter int VPOS_W = idx_width(DEF_V_PIX)
) (
    input  logic [HPOS_W-1:0] hpos,
    input  logic [VPOS_W-1:0] vpos,
    output logic              is_end
);
    localparam logic [HPOS_W-1:0] H_LAST = HPOS_W'(H_PIX - 1);
    localparam logic [VPOS_W-1:0] V_LAST = VPOS_W'(V_PIX - 1);

    assign is_end = (hpos == H_LAST) && (vpos == V_LAST);
endmodule

// File: rtl/pp_lane_gather.sv
module pp_lane_gather
    import pixpack_pkg::*;
#(
    parameter int PIX_W = DEF_PIX_W,
    parameter int LANES = DEF_LANES
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   take,
    input  logic [PIX_W-1:0]       pixel,
    input  logic                   flush,
    output logic [PIX_W*LANES-1:0] word_next,
    output logic                   word_done
);
    localparam int CNT_W = idx_width(LANES);
    localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(LANES - 1);

    logic [CNT_W-1:0] slot_q;
    logic [PIX_W-1:0] lane_q [LANES];

    // Assemble the word as it would look with the incoming pixel placed.
    for (genvar j = 0; j < LANES; j++) begin : g_lane
        localparam logic [CNT_W-1:0] J_IDX = CNT_W'(j);
        assign word_next[j*PIX_W +: PIX_W] = (slot_q == J_IDX) ? pixel : lane_q[j];
    end

    assign word_done = take && ((slot_q == CNT_TOP) || flush);

    always_ff @(posedge clk) begin
        if (rst || word_done) begin
            slot_q <= '0;
            for (int k = 0; k < LANES; k++) lane_q[k] <= '0;
        end else if (take) begin
            lane_q[slot_q] <= pixel;
            slot_q         <= slot_q + 1'b1;
        end
    end
endmodule

// File: rtl/pp_word_hold.sv
module pp_word_hold
    import pixpack_pkg::*;
#(
    parameter int WORD_W = DEF_PIX_W * DEF_LANES
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [WORD_W-1:0] word,
    input  logic              last,
    input  logic              out_ready,
    output logic              out_valid,
    output logic [WORD_W-1:0] out_data,
    output logic              out_last
);
    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_data  <= '0;
            out_last  <= 1'b0;
        end else if (load) begin
            out_valid <= 1'b1;
            out_data  <= word;
            out_last  <= last;
        end else if (out_ready) begin
            out_valid <= 1'b0;
        end
    end
endmodule

// File: rtl/pixel_word_packer.sv
module pixel_word_packer
    import pixpack_pkg::*;
#(
    parameter int PIX_W  = DEF_PIX_W,
    parameter int LANES  = DEF_LANES,
    parameter int H_PIX  = DEF_H_PIX,
    parameter int V_PIX  = DEF_V_PIX,
    parameter int HPOS_W = idx_width(H_PIX),
    parameter int VPOS_W = idx_width(V_PIX)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   in_valid,
    output logic                   in_ready,
    input  logic [PIX_W-1:0]       in_pixel,
    input  logic [HPOS_W-1:0]      in_hpos,
    input  logic [VPOS_W-1:0]      in_vpos,
    output logic                   out_valid,
    input  logic                   out_ready,
    output logic [PIX_W*LANES-1:0] out_data,
    output logic                   out_last
);
    localparam int WORD_W = PIX_W * LANES;

    logic              take;
    logic              frame_end;
    logic              word_done;
    logic [WORD_W-1:0] word_next;

    assign in_ready = !out_valid || out_ready;
    assign take     = in_valid && in_ready;

    pp_frame_end #(
        .H_PIX(H_PIX), .V_PIX(V_PIX), .HPOS_W(HPOS_W), .VPOS_W(VPOS_W)
    ) u_end (
        .hpos(in_hpos), .vpos(in_vpos), .is_end(frame_end)
    );

    pp_lane_gather #(.PIX_W(PIX_W), .LANES(LANES)) u_gather (
        .clk(clk), .rst(rst), .take(take), .pixel(in_pixel),
        .flush(frame_end), .word_next(word_next), .word_done(word_done)
    );

    pp_word_hold #(.WORD_W(WORD_W)) u_hold (
        .clk(clk), .rst(rst), .load(word_done), .word(word_next),
        .last(frame_end), .out_ready(out_ready),
        .out_valid(out_valid), .out_data(out_data), .out_last(out_last)
    );
endmodule

// File: rtl/pixel_word_packer_chk.sv
module pixel_word_packer_chk
    import pixpack_pkg::*;
#(
    parameter int PIX_W  = DEF_PIX_W,
    parameter int LANES  = DEF_LANES,
    parameter int H_PIX  = DEF_H_PIX,
    parameter int V_PIX  = DEF_V_PIX,
    parameter int HPOS_W = idx_width(H_PIX),
    parameter int VPOS_W = idx_width(V_PIX)
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   in_valid,
    input logic                   in_ready,
    input logic [HPOS_W-1:0]      in_hpos,
    input logic [VPOS_W-1:0]      in_vpos,
    input logic                   out_valid,
    input logic                   out_ready,
    input logic [PIX_W*LANES-1:0] out_data,
    input logic                   out_last
);
    localparam int CW = idx_width(LANES) + 1;

    logic          acc;
    logic          at_end;
    logic          fills;
    logic [CW-1:0] seen;

    assign acc    = in_valid && in_ready;
    assign at_end = (int'(in_hpos) == H_PIX - 1) && (int'(in_vpos) == V_PIX - 1);
    assign fills  = acc && ((int'(seen) == LANES - 1) || at_end);

    // Independent count of accepted pixels in the current group.
    always_ff @(posedge clk) begin
        if (rst || fills) seen <= '0;
        else if (acc)     seen <= seen + 1'b1;
    end

    p_stall_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));

    p_backpressure_r6: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |-> !in_ready);

    p_frame_mark_r3: assert property (@(posedge clk) disable iff (rst)
        (acc && at_end) |=> (out_valid && out_last));

    p_full_group_r2: assert property (@(posedge clk) disable iff (rst)
        (acc && (int'(seen) == LANES - 1)) |=> out_valid);

    p_drain_r8: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_ready && !fills) |=> !out_valid);

    p_reset_clear_r7: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !out_valid);
endmodule

bind pixel_word_packer pixel_word_packer_chk #(
    .PIX_W(PIX_W), .LANES(LANES), .H_PIX(H_PIX), .V_PIX(V_PIX),
    .HPOS_W(HPOS_W), .VPOS_W(VPOS_W)
) u_chk (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_hpos(in_hpos), .in_vpos(in_vpos), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .out_last(out_last)
);

// File: tb/pixel_word_packer_tb.sv
module pixel_word_packer_tb;
    localparam int PIX_W  = 16;
    localparam int LANES  = 8;
    localparam int H_PIX  = 4;
    localparam int V_PIX  = 3;
    localparam int HPOS_W = 2;
    localparam int VPOS_W = 2;
    localparam int FPIX   = H_PIX * V_PIX;              // 12 pixels per frame
    localparam int WPF    = (FPIX + LANES - 1) / LANES; // 2 words per frame

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0;
    logic in_ready;
    logic [PIX_W-1:0]  in_pixel = '0;
    logic [HPOS_W-1:0] in_hpos = '0;
    logic [VPOS_W-1:0] in_vpos = '0;
    logic out_valid;
    logic out_ready = 1'b0;
    logic [PIX_W*LANES-1:0] out_data;
    logic out_last;

    int total = 0;
    int bad   = 0;
    int idx   = 0;   // global pixel index since the last reset
    int wcnt  = 0;   // global word index since the last reset
    bit done  = 1'b0;

    always #10 clk = ~clk;  // 50 MHz

    pixel_word_packer #(
        .PIX_W(PIX_W), .LANES(LANES), .H_PIX(H_PIX), .V_PIX(V_PIX),
        .HPOS_W(HPOS_W), .VPOS_W(VPOS_W)
    ) u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_pixel(in_pixel), .in_hpos(in_hpos), .in_vpos(in_vpos),
        .out_valid(out_valid), .out_ready(out_ready),
        .out_data(out_data), .out_last(out_last)
    );

    function automatic logic [PIX_W-1:0] pix_val(input int g);
        return PIX_W'(((g / FPIX) * 256) + (g % FPIX) + 16'h4000);
    endfunction

    // Expected word w: slot j holds frame pixel 8k+j (R1), zero past frame end (R4).
    function automatic logic [PIX_W*LANES-1:0] exp_word(input int w);
        logic [PIX_W*LANES-1:0] r;
        int f, k, p;
        f = w / WPF;
        k = w % WPF;
        r = '0;
        for (int j = 0; j < LANES; j++) begin
            p = k * LANES + j;
            if (p < FPIX) r[j*PIX_W +: PIX_W] = pix_val(f * FPIX + p);
        end
        return r;
    endfunction

    task automatic check(input bit ok, input string req, input logic [127:0] act,
                         input logic [127:0] expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    task automatic set_pixel();
        int p;
        p = idx % FPIX;
        in_pixel = pix_val(idx);
        in_hpos  = HPOS_W'(p % H_PIX);
        in_vpos  = VPOS_W'(p / H_PIX);
    endtask

    // One bench cycle: drive at the falling edge, observe what the next rising edge will take.
    task automatic step(input int vmode, input int rmode, input int limit);
        @(negedge clk);
        out_ready = (rmode == 0) ? 1'b1 : (rmode == 1) ? ($urandom_range(0, 2) != 0)
                                       : ($urandom_range(0, 3) == 0);
        in_valid  = (idx < limit) && ((vmode == 0) ? 1'b1 : ($urandom_range(0, 2) != 0));
        set_pixel();
        #1;
        if (out_valid && !out_ready)
            check(!in_ready, "R6 in_ready under backpressure", 128'(in_ready), 128'(0));
        if (out_valid && out_ready) begin
            check(out_data == exp_word(wcnt), "R1/R4/R5 word content", out_data, exp_word(wcnt));
            check(out_last == ((wcnt % WPF) == WPF - 1), "R3 last flag",
                  128'(out_last), 128'((wcnt % WPF) == WPF - 1));
            wcnt++;
        end
        if (in_valid && in_ready) idx++;
    endtask

    task automatic run_frames(input int frames, input int vmode, input int rmode);
        int limit;
        limit = idx + frames * FPIX;
        while (wcnt < (limit / FPIX) * WPF) step(vmode, rmode, limit);
        @(negedge clk);
        in_valid  = 1'b0;
        out_ready = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // R7: reset state
        check(!out_valid, "R7 out_valid after reset", 128'(out_valid), 128'(0));
        check(in_ready, "R6 in_ready idle", 128'(in_ready), 128'(1));

        // R7: interrupt a group after three pixels, then reset
        out_ready = 1'b0;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            in_valid = 1'b1;
            set_pixel();
            idx++;
        end
        @(negedge clk);
        in_valid = 1'b0;
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        idx = 0;
        wcnt = 0;
        #1;
        check(!out_valid, "R7 out_valid after mid-group reset", 128'(out_valid), 128'(0));

        // R2: eight pixels with the output stalled; the word appears one cycle after the 8th
        for (int i = 0; i < LANES; i++) begin
            @(negedge clk);
            in_valid = 1'b1;
            set_pixel();
            #1;
            check(!out_valid, "R2 no word before slot 8", 128'(out_valid), 128'(0));
            idx++;
        end
        @(negedge clk);
        in_valid = 1'b0;
        #1;
        check(out_valid, "R2 word after 8 pixels", 128'(out_valid), 128'(1));
        check(out_data == exp_word(0), "R1 R7 first word starts at slot 0", out_data, exp_word(0));
        check(!in_ready, "R6 stalled input", 128'(in_ready), 128'(0));
        repeat (3) @(negedge clk);
        #1;
        check(out_valid && out_data == exp_word(0), "R5 held while stalled", out_data, exp_word(0));
        // Take it; no new word follows, so valid must drop (R8)
        out_ready = 1'b1;
        @(negedge clk);
        out_ready = 1'b0;
        wcnt = 1;
        #1;
        check(!out_valid, "R8 valid drops after take", 128'(out_valid), 128'(0));

        // R4: remaining four pixels end the frame on a partial word
        for (int i = 0; i < FPIX - LANES; i++) begin
            @(negedge clk);
            in_valid = 1'b1;
            set_pixel();
            idx++;
        end
        @(negedge clk);
        in_valid = 1'b0;
        #1;
        check(out_valid && out_last, "R4 partial word flagged last",
              128'({out_valid, out_last}), 128'(3));
        check(out_data == exp_word(1), "R4 zero fill", out_data, exp_word(1));
        out_ready = 1'b1;
        @(negedge clk);
        out_ready = 1'b0;
        wcnt = 2;

        // Streaming sweeps with varying gaps and backpressure (R1..R6, R8)
        run_frames(4, 0, 0);
        run_frames(4, 1, 0);
        run_frames(4, 0, 1);
        run_frames(4, 1, 2);
        run_frames(4, 1, 1);
        check(wcnt == idx / FPIX * WPF, "R5 no lost words", 128'(wcnt), 128'(idx / FPIX * WPF));
        done = 1'b1;
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < 100000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=<100000", cyc);
        end
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule